// File: doc/BRIEF.md
# Segment Relocation and Limit Unit

This block turns effective addresses into physical addresses for a simple segmented machine. It keeps two independent segment descriptors, one for instruction fetch and one for loads and stores. Each descriptor is a relocation value (the physical start of the segment) and a limit (the segment length). On each path the unrelocated effective address is compared against that path's limit. If it is in range, the relocation value is added to it to give the physical address. If it is out of range, a fault is flagged and no physical address is presented.

The four descriptor registers sit behind a small configuration port. Only the privileged (supervisor) mode may read or write them. An access attempted from user mode changes nothing, reads back as zero and raises a one-cycle privilege-error pulse. After reset every descriptor is zero, so every access faults until privileged software loads the descriptors. Translation is combinational from request to result. Descriptor updates take effect at the clock edge.

Top module: `seg_reloc_unit`

## Requirements
- R1: A fetch request whose address is below the fetch limit produces `fetch_pa` = `fetch_va` + fetch relocation, taken modulo 2^PA_W, with `fetch_pa_valid` high in the same cycle.
- R2: A data request whose address is below the data limit produces `data_pa` = `data_va` + data relocation, taken modulo 2^PA_W, with `data_pa_valid` high in the same cycle.
- R3: A request faults exactly when its unrelocated address, compared unsigned, is greater than or equal to its path's limit. The address limit-1 passes, the address equal to the limit faults, and a limit of 2^VA_W admits every address.
- R4: `*_pa_valid` is high only when the request is present and has not faulted. With no request, both valid and fault stay low.
- R5: A privileged write (`cfg_we`=1, `sup_mode`=1) loads `cfg_wdata` into the register chosen by `cfg_sel` at the clock edge: 0 = fetch relocation, 1 = fetch limit, 2 = data relocation, 3 = data limit.
- R6: A configuration write made with `sup_mode`=0 leaves all four registers unchanged.
- R7: `priv_err` is high for exactly the one cycle after a clock edge at which `cfg_we` or `cfg_re` was high with `sup_mode`=0, and is low otherwise.
- R8: With `sup_mode`=1, `cfg_rdata` shows the register chosen by `cfg_sel`. With `sup_mode`=0 it reads zero.
- R9: After reset all four registers are zero, so any request on either path faults.
- R10: The fetch path uses only the fetch pair and the data path uses only the data pair, so a change to one pair leaves the other path's results unchanged.
- R11: A request made in the same cycle as a write to its own path's register is translated with the value held before that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_mode | input | 1 | 1 while the processor runs in privileged mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Register select (0 fetch reloc, 1 fetch limit, 2 data reloc, 3 data limit) |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Configuration read data, zero outside privileged mode |
| priv_err | output | 1 | One-cycle pulse on a user-mode configuration access |
| fetch_req | input | 1 | Fetch address valid |
| fetch_va | input | VA_W | Program-counter effective address |
| fetch_pa_valid | output | 1 | Fetch physical address valid |
| fetch_pa | output | PA_W | Fetch physical address |
| fetch_fault | output | 1 | Fetch limit violation |
| data_req | input | 1 | Load/store address valid |
| data_va | input | VA_W | Load/store effective address |
| data_pa_valid | output | 1 | Data physical address valid |
| data_pa | output | PA_W | Data physical address |
| data_fault | output | 1 | Data limit violation |

## Verification
A descriptor write and a translation on the same path can fall in one cycle. The bench provokes this by raising a data request against an address beyond the current data limit while, in that same cycle, a privileged write raises that limit. It judges the result by sampling before the edge, where the fault must still show because the old limit applies, and again after the edge, where the same request must translate with the new limit and the unchanged relocation. Fetch and data requests are also issued together, so that each path is judged against its own pair only.

// File: rtl/seg_reloc_pkg.sv
`timescale 1ns/1ps
package seg_reloc_pkg;

   localparam int NUM_REGS  = 4;
   localparam int NUM_PATHS = 2;
   localparam int SEL_W     = $clog2(NUM_REGS);

   // Register select encoding; the decode depends on this order.
   typedef enum logic [SEL_W-1:0] {
      SEL_FETCH_RELOC = 2'd0,
      SEL_FETCH_LIMIT = 2'd1,
      SEL_DATA_RELOC  = 2'd2,
      SEL_DATA_LIMIT  = 2'd3
   } cfg_sel_e;

   localparam int PATH_FETCH = 0;
   localparam int PATH_DATA  = 1;

   // Register index holding the relocation / limit of a path.
   function automatic int reloc_idx(input int path);
      return (path == PATH_FETCH) ? int'(SEL_FETCH_RELOC) : int'(SEL_DATA_RELOC);
   endfunction

   function automatic int limit_idx(input int path);
      return (path == PATH_FETCH) ? int'(SEL_FETCH_LIMIT) : int'(SEL_DATA_LIMIT);
   endfunction

endpackage

// File: rtl/seg_reloc_regs.sv
`timescale 1ns/1ps
module seg_reloc_regs
   import seg_reloc_pkg::*;
#(
   parameter int CFG_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup_mode,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              priv_err,
   output logic [CFG_W-1:0]  reg_q [NUM_REGS]
);

   logic wr_ok;
   logic bad_access;

   assign wr_ok      = cfg_we & sup_mode;
   assign bad_access = (cfg_we | cfg_re) & ~sup_mode;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      assign hit = wr_ok && (cfg_sel == SEL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_q[i] <= '0;
         end else if (hit) begin
            reg_q[i] <= cfg_wdata;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (sup_mode) begin
         cfg_rdata = reg_q[cfg_sel];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_err <= 1'b0;
      end else begin
         priv_err <= bad_access;
      end
   end

endmodule

// File: rtl/seg_reloc_path.sv
`timescale 1ns/1ps
module seg_reloc_path #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 20,
   parameter int CFG_W = 20
) (
   input  logic             req,
   input  logic [VA_W-1:0]  va,
   input  logic [PA_W-1:0]  reloc,
   input  logic [CFG_W-1:0] limit,
   output logic             pa_valid,
   output logic [PA_W-1:0]  pa,
   output logic             fault
);

   logic [PA_W-1:0]  va_pa;
   logic [CFG_W-1:0] va_cmp;
   logic             over;

   // Width adaptation of the effective address for the adder.
   if (PA_W > VA_W) begin : g_pa_ext
      assign va_pa = {{(PA_W-VA_W){1'b0}}, va};
   end else begin : g_pa_same
      assign va_pa = va;
   end

   // Width adaptation of the effective address for the limit compare.
   if (CFG_W > VA_W) begin : g_cmp_ext
      assign va_cmp = {{(CFG_W-VA_W){1'b0}}, va};
   end else begin : g_cmp_same
      assign va_cmp = va;
   end

   assign over     = (va_cmp >= limit);
   assign fault    = req & over;
   assign pa_valid = req & ~over;
   assign pa       = va_pa + reloc;

endmodule

// File: rtl/seg_reloc_unit.sv
`timescale 1ns/1ps
module seg_reloc_unit
   import seg_reloc_pkg::*;
#(
   parameter int VA_W  = 16,
   parameter int PA_W  = 20,
   parameter int CFG_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sup_mode,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              priv_err,
   input  logic              fetch_req,
   input  logic [VA_W-1:0]   fetch_va,
   output logic              fetch_pa_valid,
   output logic [PA_W-1:0]   fetch_pa,
   output logic              fetch_fault,
   input  logic              data_req,
   input  logic [VA_W-1:0]   data_va,
   output logic              data_pa_valid,
   output logic [PA_W-1:0]   data_pa,
   output logic              data_fault
);

   // Elaboration-time parameter checks.
   if (PA_W < VA_W) begin : g_bad_pa
      $error("seg_reloc_unit: PA_W must be at least VA_W");
   end
   if (CFG_W < PA_W) begin : g_bad_cfg_pa
      $error("seg_reloc_unit: CFG_W must be at least PA_W");
   end
   if (CFG_W <= VA_W) begin : g_bad_cfg_va
      $error("seg_reloc_unit: CFG_W must exceed VA_W so a limit can span the space");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("seg_reloc_unit: select width must be 2");
   end

   logic [CFG_W-1:0] reg_q [NUM_REGS];

   seg_reloc_regs #(.CFG_W(CFG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_mode  (sup_mode),
      .cfg_we    (cfg_we),
      .cfg_re    (cfg_re),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .priv_err  (priv_err),
      .reg_q     (reg_q)
   );

   logic             p_req   [NUM_PATHS];
   logic [VA_W-1:0]  p_va    [NUM_PATHS];
   logic             p_valid [NUM_PATHS];
   logic [PA_W-1:0]  p_pa    [NUM_PATHS];
   logic             p_fault [NUM_PATHS];

   assign p_req[PATH_FETCH] = fetch_req;
   assign p_va[PATH_FETCH]  = fetch_va;
   assign p_req[PATH_DATA]  = data_req;
   assign p_va[PATH_DATA]   = data_va;

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      logic [CFG_W-1:0] reloc_full;
      assign reloc_full = reg_q[reloc_idx(p)];
      seg_reloc_path #(.VA_W(VA_W), .PA_W(PA_W), .CFG_W(CFG_W)) u_path (
         .req      (p_req[p]),
         .va       (p_va[p]),
         .reloc    (reloc_full[PA_W-1:0]),
         .limit    (reg_q[limit_idx(p)]),
         .pa_valid (p_valid[p]),
         .pa       (p_pa[p]),
         .fault    (p_fault[p])
      );
   end

   assign fetch_pa_valid = p_valid[PATH_FETCH];
   assign fetch_pa       = p_pa[PATH_FETCH];
   assign fetch_fault    = p_fault[PATH_FETCH];
   assign data_pa_valid  = p_valid[PATH_DATA];
   assign data_pa        = p_pa[PATH_DATA];
   assign data_fault     = p_fault[PATH_DATA];

   // Named views of the descriptor state for the bound checker.
   logic [CFG_W-1:0] fetch_reloc_q, fetch_limit_q, data_reloc_q, data_limit_q;
   assign fetch_reloc_q = reg_q[SEL_FETCH_RELOC];
   assign fetch_limit_q = reg_q[SEL_FETCH_LIMIT];
   assign data_reloc_q  = reg_q[SEL_DATA_RELOC];
   assign data_limit_q  = reg_q[SEL_DATA_LIMIT];

endmodule

// File: rtl/seg_reloc_chk.sv
`timescale 1ns/1ps
module seg_reloc_chk #(
   parameter int VA_W  = 16,
   parameter int PA_W  = 20,
   parameter int CFG_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sup_mode,
   input logic             cfg_we,
   input logic             cfg_re,
   input logic [1:0]       cfg_sel,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic             priv_err,
   input logic             fetch_req,
   input logic [VA_W-1:0]  fetch_va,
   input logic             fetch_pa_valid,
   input logic             fetch_fault,
   input logic             data_req,
   input logic             data_pa_valid,
   input logic             data_fault,
   input logic [CFG_W-1:0] fetch_reloc_q,
   input logic [CFG_W-1:0] fetch_limit_q,
   input logic [CFG_W-1:0] data_reloc_q,
   input logic [CFG_W-1:0] data_limit_q
);

   // R4: a valid physical address never coexists with a fault.
   a_r4_fetch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_pa_valid |-> (fetch_req && !fetch_fault));
   a_r4_data_excl: assert property (@(posedge clk) disable iff (!rst_n)
      data_pa_valid |-> (data_req && !data_fault));

   // R4: no result without a request.
   a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_req && !data_req) |-> !(fetch_fault || data_fault || fetch_pa_valid || data_pa_valid));

   // R3: fetch at or above the fetch limit faults.
   a_r3_fetch_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && ({{(CFG_W-VA_W){1'b0}}, fetch_va} >= fetch_limit_q)) |-> fetch_fault);

   // R6: a user-mode write leaves every descriptor unchanged.
   a_r6_user_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !sup_mode) |=> ($stable(fetch_reloc_q) && $stable(fetch_limit_q)
                                 && $stable(data_reloc_q) && $stable(data_limit_q)));

   // R5: a privileged write to the data limit lands at the edge.
   a_r5_data_limit_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && sup_mode && cfg_sel == 2'd3) |=> (data_limit_q == $past(cfg_wdata)));

   // R7: user-mode access produces the pulse; the pulse needs such an access.
   a_r7_priv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_we || cfg_re) && !sup_mode) |=> priv_err);
   a_r7_priv_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_we || cfg_re) == 1'b0 || sup_mode) |=> !priv_err);

endmodule

bind seg_reloc_unit seg_reloc_chk #(.VA_W(VA_W), .PA_W(PA_W), .CFG_W(CFG_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sup_mode       (sup_mode),
   .cfg_we         (cfg_we),
   .cfg_re         (cfg_re),
   .cfg_sel        (cfg_sel),
   .cfg_wdata      (cfg_wdata),
   .priv_err       (priv_err),
   .fetch_req      (fetch_req),
   .fetch_va       (fetch_va),
   .fetch_pa_valid (fetch_pa_valid),
   .fetch_fault    (fetch_fault),
   .data_req       (data_req),
   .data_pa_valid  (data_pa_valid),
   .data_fault     (data_fault),
   .fetch_reloc_q  (fetch_reloc_q),
   .fetch_limit_q  (fetch_limit_q),
   .data_reloc_q   (data_reloc_q),
   .data_limit_q   (data_limit_q)
);

// File: tb/seg_reloc_unit_tb.sv
`timescale 1ns/1ps
module seg_reloc_unit_tb_top;

   localparam int VA_W  = 16;
   localparam int PA_W  = 20;
   localparam int CFG_W = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sup_mode = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_re = 1'b0;
   logic [1:0]       cfg_sel = '0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CFG_W-1:0] cfg_rdata;
   logic             priv_err;
   logic             fetch_req = 1'b0;
   logic [VA_W-1:0]  fetch_va = '0;
   logic             fetch_pa_valid;
   logic [PA_W-1:0]  fetch_pa;
   logic             fetch_fault;
   logic             data_req = 1'b0;
   logic [VA_W-1:0]  data_va = '0;
   logic             data_pa_valid;
   logic [PA_W-1:0]  data_pa;
   logic             data_fault;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   seg_reloc_unit #(.VA_W(VA_W), .PA_W(PA_W), .CFG_W(CFG_W)) dut_i (.*);

   // Row: {is_data, exp_fault, va[15:0], exp_pa[19:0]}
   localparam int NROW = 8;
   localparam logic [37:0] VEC [NROW] = '{
      {1'b0, 1'b0, 16'h0000, 20'h10000},
      {1'b0, 1'b0, 16'h07FF, 20'h107FF},
      {1'b0, 1'b1, 16'h0800, 20'h00000},
      {1'b0, 1'b1, 16'hFFFF, 20'h00000},
      {1'b1, 1'b0, 16'h0000, 20'hFF000},
      {1'b1, 1'b0, 16'h0FFF, 20'hFFFFF},
      {1'b1, 1'b0, 16'h1800, 20'h00800},
      {1'b1, 1'b1, 16'h2000, 20'h00000}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One configuration access; returns read data (before edge) and priv_err (after edge).
   task automatic cfg_op(input bit sup, input bit we, input bit re, input logic [1:0] sel,
                         input logic [CFG_W-1:0] wd, output logic [CFG_W-1:0] rd, output logic perr);
      @(negedge clk);
      sup_mode = sup; cfg_we = we; cfg_re = re; cfg_sel = sel; cfg_wdata = wd;
      #5 rd = cfg_rdata;
      @(negedge clk);
      cfg_we = 1'b0; cfg_re = 1'b0;
      #1 perr = priv_err;
   endtask

   // Drive both paths, sample mid-cycle.
   task automatic xlate(input bit fr, input logic [VA_W-1:0] fv, input bit dr, input logic [VA_W-1:0] dv);
      @(negedge clk);
      fetch_req = fr; fetch_va = fv; data_req = dr; data_va = dv;
      #5;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [CFG_W-1:0] rd;
      logic             pe;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9: reset state
      for (int i = 0; i < 4; i++) begin
         cfg_op(1'b1, 1'b0, 1'b1, 2'(i), '0, rd, pe);
         chk(rd == '0, "R9 reset register zero", rd, 0);
      end
      xlate(1'b1, 16'h0000, 1'b1, 16'h0000);
      chk(fetch_fault && !fetch_pa_valid, "R9 fetch faults after reset", {fetch_fault, fetch_pa_valid}, 2'b10);
      chk(data_fault && !data_pa_valid, "R9 data faults after reset", {data_fault, data_pa_valid}, 2'b10);
      xlate(1'b0, '0, 1'b0, '0);

      // R5 / R8: privileged programming and read-back
      cfg_op(1'b1, 1'b1, 1'b0, 2'd0, 20'h10000, rd, pe);
      chk(!pe, "R7 no pulse in supervisor", pe, 0);
      cfg_op(1'b1, 1'b1, 1'b0, 2'd1, 20'h00800, rd, pe);
      cfg_op(1'b1, 1'b1, 1'b0, 2'd2, 20'hFF000, rd, pe);
      cfg_op(1'b1, 1'b1, 1'b0, 2'd3, 20'h02000, rd, pe);
      cfg_op(1'b1, 1'b0, 1'b1, 2'd0, '0, rd, pe);
      chk(rd == 20'h10000, "R5 R8 fetch reloc readback", rd, 20'h10000);
      cfg_op(1'b1, 1'b0, 1'b1, 2'd3, '0, rd, pe);
      chk(rd == 20'h02000, "R5 R8 data limit readback", rd, 20'h02000);

      // R1 R2 R3 R4: vector table
      for (int r = 0; r < NROW; r++) begin
         logic            isd, ef;
         logic [15:0]     va;
         logic [19:0]     epa;
         {isd, ef, va, epa} = VEC[r];
         if (isd) begin
            xlate(1'b0, '0, 1'b1, va);
            chk(data_fault == ef && data_pa_valid == !ef, "R3 R4 data fault/valid", {data_fault, data_pa_valid}, {ef, !ef});
            if (!ef) chk(data_pa == epa, "R2 data physical address", data_pa, epa);
         end else begin
            xlate(1'b1, va, 1'b0, '0);
            chk(fetch_fault == ef && fetch_pa_valid == !ef, "R3 R4 fetch fault/valid", {fetch_fault, fetch_pa_valid}, {ef, !ef});
            if (!ef) chk(fetch_pa == epa, "R1 fetch physical address", fetch_pa, epa);
         end
      end

      // R4: idle
      xlate(1'b0, 16'h0900, 1'b0, 16'h3000);
      chk(!fetch_fault && !data_fault && !fetch_pa_valid && !data_pa_valid, "R4 idle outputs quiet",
          {fetch_fault, data_fault, fetch_pa_valid, data_pa_valid}, 0);

      // R6 R7: user write ignored
      cfg_op(1'b0, 1'b1, 1'b0, 2'd1, 20'h0FFFF, rd, pe);
      chk(pe, "R7 pulse after user write", pe, 1);
      @(negedge clk) #1;
      chk(!priv_err, "R7 pulse lasts one cycle", priv_err, 0);
      cfg_op(1'b1, 1'b0, 1'b1, 2'd1, '0, rd, pe);
      chk(rd == 20'h00800, "R6 fetch limit unchanged", rd, 20'h00800);
      xlate(1'b1, 16'h0800, 1'b0, '0);
      chk(fetch_fault, "R6 fetch still faults at old limit", fetch_fault, 1);
      xlate(1'b0, '0, 1'b0, '0);

      // R8 R7: user read
      cfg_op(1'b0, 1'b0, 1'b1, 2'd0, '0, rd, pe);
      chk(rd == '0, "R8 user read returns zero", rd, 0);
      chk(pe, "R7 pulse after user read", pe, 1);

      // R10: data limit to zero, fetch unaffected; both paths together
      cfg_op(1'b1, 1'b1, 1'b0, 2'd3, 20'h00000, rd, pe);
      xlate(1'b1, 16'h0010, 1'b1, 16'h0000);
      chk(fetch_pa_valid && fetch_pa == 20'h10010, "R10 fetch independent of data pair", fetch_pa, 20'h10010);
      chk(data_fault, "R10 data faults with zero limit", data_fault, 1);

      // R11: same-cycle write to data limit and data request
      @(negedge clk);
      fetch_req = 1'b0; data_req = 1'b1; data_va = 16'h0010;
      sup_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 20'h00100;
      #5;
      chk(data_fault && !data_pa_valid, "R11 old limit before edge", data_fault, 1);
      @(negedge clk);
      cfg_we = 1'b0;
      #5;
      chk(data_pa_valid && data_pa == 20'hFF010, "R11 new limit after edge", data_pa, 20'hFF010);
      data_req = 1'b0;

      // R3: limit spanning the whole space
      cfg_op(1'b1, 1'b1, 1'b0, 2'd1, 20'h10000, rd, pe);
      xlate(1'b1, 16'hFFFF, 1'b0, '0);
      chk(fetch_pa_valid && fetch_pa == 20'h1FFFF, "R3 R1 full-span limit admits top address", fetch_pa, 20'h1FFFF);
      xlate(1'b0, '0, 1'b0, '0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule